// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block lets any CPU of a small cluster signal any set of other CPUs. A CPU writes a trigger word that names one doorbell and carries a bitmap of target CPUs. Every targeted CPU latches that doorbell in its own cause register. Each CPU also owns a mask register, which selects the doorbells it listens to, and a gate bit. When the gate is set and at least one cause bit is both pending and unmasked, that CPU's doorbell request is raised towards its interrupt controller.

Every CPU has its own register port. Through that port it reaches the global trigger register and its own banked window of cause, mask, gate and acknowledge registers. All CPU ports operate in the same cycle. Triggers issued together from several CPUs merge. A trigger that lands in the same cycle as a cause write keeps its bit. Reads return data one cycle after the request. The acknowledge register returns ID 0 while a doorbell request is active, and returns the spurious ID 1023 otherwise.

Top module: `db_doorbell_unit`

## Requirements
- R1: After a synchronous active-low reset, every cause, mask and gate register is 0, every db_req bit is 0, and every bus_rvalid and bus_rdata field is 0.
- R2: A write to offset 0x04 carries the doorbell number in bits [7:0] and a target bitmap in bits [8+N_CPU-1:8], where bit 8+k selects CPU k. The write sets the named bit in the cause register (offset 0x88) of every selected CPU, and the bit can be read back from the next cycle on.
- R3: A trigger write has no effect on any register when its doorbell number is N_BELL or more, or when its target bitmap is 0.
- R4: Trigger writes issued in the same cycle from several CPU ports all take effect, and their bits merge (OR) in each target's cause register.
- R5: A write to a CPU's cause register loads bits [N_BELL-1:0] of the written value, so writing 0 clears all pending doorbells. A trigger in the same cycle still sets its bit in that register.
- R6: A write to offset 0x8C stores bits [N_BELL-1:0] in the CPU's mask register, where a 1 enables the matching doorbell. A read of the mask register returns that value zero-extended.
- R7: db_req[k] is 1 exactly when CPU k's gate is 1 and its cause AND mask is nonzero. It follows register writes in the next cycle.
- R8: A read of offset 0xC4 returns 0 when that CPU's db_req was 1 in the read cycle, and returns 1023 otherwise.
- R9: A read gives bus_rvalid and bus_rdata one cycle after bus_rd. Offset 0x04 and unmapped offsets read 0. Writes to unmapped offsets change nothing. With no read, bus_rvalid and bus_rdata are 0.
- R10: A write to offset 0x90 stores bit 0 as the CPU's gate bit, and a read of offset 0x90 returns it in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | N_CPU | Write strobe, one per CPU port |
| bus_rd | input | N_CPU | Read strobe, one per CPU port |
| bus_addr | input | N_CPU*8 | Byte offset, 8 bits per CPU port |
| bus_wdata | input | N_CPU*DATA_W | Write data per CPU port |
| bus_rdata | output | N_CPU*DATA_W | Read data per CPU port, one cycle after bus_rd |
| bus_rvalid | output | N_CPU | Read data valid per CPU port |
| db_req | output | N_CPU | Doorbell request per CPU towards its interrupt controller |

## Verification
The bench builds the block with its defaults: four CPUs, eight doorbells and 32-bit data. With four ports, one cycle can hold a cause write on one CPU together with triggers from the other three, including triggers aimed at that same CPU. This makes the merge cases and the trigger-over-write priority reachable. Random doorbell numbers range up to 9, so out-of-range triggers occur next to valid ones. The four-bit target maps cover the empty map, single targets and broadcasts.

// File: rtl/db_pkg.sv
// Package: shared offsets, register select type and decode for the doorbell unit.
// Assumes an 8-bit byte offset per CPU port; the banked window sits at 0x80.
package db_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_TRIGGER = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CAUSE   = 8'h88;
    localparam logic [ADDR_W-1:0] OFF_MASK    = 8'h8C;
    localparam logic [ADDR_W-1:0] OFF_GATE    = 8'h90;
    localparam logic [ADDR_W-1:0] OFF_ACK     = 8'hC4;

    localparam logic [9:0] ACK_ID_BELL     = 10'd0;
    localparam logic [9:0] ACK_ID_SPURIOUS = 10'd1023;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TRIGGER,
        SEL_CAUSE,
        SEL_MASK,
        SEL_GATE,
        SEL_ACK
    } reg_sel_e;

    // Map a byte offset to the register it selects.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_TRIGGER: return SEL_TRIGGER;
            OFF_CAUSE:   return SEL_CAUSE;
            OFF_MASK:    return SEL_MASK;
            OFF_GATE:    return SEL_GATE;
            OFF_ACK:     return SEL_ACK;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/db_trigger_fanout.sv
// Trigger fan-out: turns the trigger writes of all CPU ports in one cycle into
// per-target set vectors for the cause registers.
// Assumes bits [7:0] hold the doorbell number and bits [8+N_CPU-1:8] the target map.
module db_trigger_fanout
    import db_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int N_BELL = 8,
    parameter int DATA_W = 32
) (
    input  logic [N_CPU-1:0]          wr,
    input  logic [N_CPU*ADDR_W-1:0]   addr,
    input  logic [N_CPU*DATA_W-1:0]   wdata,
    output logic [N_CPU*N_BELL-1:0]   set_flat
);

    localparam int MAP_LSB = 8;

    // Per-source one-hot doorbell vector, zero when the source is not a valid trigger.
    logic [N_BELL-1:0] bell_hot [N_CPU];

    // Decode each source's doorbell number into a one-hot vector.
    always_comb begin
        for (int s = 0; s < N_CPU; s++) begin
            for (int b = 0; b < N_BELL; b++) begin
                bell_hot[s][b] = wr[s]
                    && (decode_addr(addr[s*ADDR_W +: ADDR_W]) == SEL_TRIGGER)
                    && (wdata[s*DATA_W +: 8] == 8'(b));
            end
        end
    end

    // OR every source's doorbell into each target it selects.
    always_comb begin
        set_flat = '0;
        for (int s = 0; s < N_CPU; s++) begin
            for (int t = 0; t < N_CPU; t++) begin
                if (wdata[s*DATA_W + MAP_LSB + t]) begin
                    set_flat[t*N_BELL +: N_BELL] = set_flat[t*N_BELL +: N_BELL] | bell_hot[s];
                end
            end
        end
    end

endmodule

// File: rtl/db_cpu_bank.sv
// Per-CPU bank: holds the cause, mask and gate registers of one CPU, forms its
// doorbell request and serves its register reads with one cycle of latency.
// Assumes the set vector comes from the trigger fan-out in the same cycle.
module db_cpu_bank
    import db_pkg::*;
#(
    parameter int N_BELL = 8,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [N_BELL-1:0]  wdata_low,
    input  logic [N_BELL-1:0]  set_bits,
    output logic [DATA_W-1:0]  rdata,
    output logic               rvalid,
    output logic               req,
    output logic [N_BELL-1:0]  cause_q,
    output logic [N_BELL-1:0]  mask_q
);

    reg_sel_e          sel;
    logic              gate_q;
    logic [DATA_W-1:0] rd_mux;

    assign sel = decode_addr(addr);

    // Cause, mask and gate storage; a trigger set bit wins over a cause write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '0;
            gate_q  <= 1'b0;
        end else begin
            cause_q <= ((wr && sel == SEL_CAUSE) ? wdata_low : cause_q) | set_bits;
            if (wr && sel == SEL_MASK) mask_q <= wdata_low;
            if (wr && sel == SEL_GATE) gate_q <= wdata_low[0];
        end
    end

    // Doorbell request: gated OR of pending and enabled doorbells.
    assign req = gate_q && |(cause_q & mask_q);

    // Read multiplexer over the banked registers.
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CAUSE: rd_mux[N_BELL-1:0] = cause_q;
            SEL_MASK:  rd_mux[N_BELL-1:0] = mask_q;
            SEL_GATE:  rd_mux[0]          = gate_q;
            SEL_ACK:   rd_mux[9:0]        = req ? ACK_ID_BELL : ACK_ID_SPURIOUS;
            default:   rd_mux = '0;
        endcase
    end

    // Registered read return with valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd;
            rdata  <= rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/db_doorbell_unit.sv
// Top: inter-processor doorbell unit with one register port per CPU.
// Each port reaches the global trigger register and its own banked window.
// Assumes N_CPU + 8 <= DATA_W so the target map fits in the trigger word.
module db_doorbell_unit
    import db_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int N_BELL = 8,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CPU-1:0]          bus_wr,
    input  logic [N_CPU-1:0]          bus_rd,
    input  logic [N_CPU*8-1:0]        bus_addr,
    input  logic [N_CPU*DATA_W-1:0]   bus_wdata,
    output logic [N_CPU*DATA_W-1:0]   bus_rdata,
    output logic [N_CPU-1:0]          bus_rvalid,
    output logic [N_CPU-1:0]          db_req
);

    localparam int FLAT_W = N_CPU * N_BELL;

    logic [FLAT_W-1:0] set_flat;
    logic [FLAT_W-1:0] cause_flat;
    logic [FLAT_W-1:0] mask_flat;

    db_trigger_fanout #(
        .N_CPU (N_CPU),
        .N_BELL(N_BELL),
        .DATA_W(DATA_W)
    ) u_fanout (
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .set_flat(set_flat)
    );

    for (genvar c = 0; c < N_CPU; c++) begin : g_bank
        db_cpu_bank #(
            .N_BELL(N_BELL),
            .DATA_W(DATA_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (bus_wr[c]),
            .rd       (bus_rd[c]),
            .addr     (bus_addr[c*ADDR_W +: ADDR_W]),
            .wdata_low(bus_wdata[c*DATA_W +: N_BELL]),
            .set_bits (set_flat[c*N_BELL +: N_BELL]),
            .rdata    (bus_rdata[c*DATA_W +: DATA_W]),
            .rvalid   (bus_rvalid[c]),
            .req      (db_req[c]),
            .cause_q  (cause_flat[c*N_BELL +: N_BELL]),
            .mask_q   (mask_flat[c*N_BELL +: N_BELL])
        );
    end

endmodule

// File: rtl/db_doorbell_unit_sva.sv
// Checker for the doorbell unit: port timing, acknowledge ID and cause retention.
module db_doorbell_unit_sva
    import db_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int N_BELL = 8,
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_CPU-1:0]          bus_wr,
    input logic [N_CPU-1:0]          bus_rd,
    input logic [N_CPU*8-1:0]        bus_addr,
    input logic [N_CPU*DATA_W-1:0]   bus_rdata,
    input logic [N_CPU-1:0]          bus_rvalid,
    input logic [N_CPU-1:0]          db_req,
    input logic [N_CPU*N_BELL-1:0]   cause_flat,
    input logic [N_CPU*N_BELL-1:0]   mask_flat
);

    for (genvar c = 0; c < N_CPU; c++) begin : g_chk
        // R9: a read strobe yields valid data one cycle later.
        a_r9_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rd[c] |=> bus_rvalid[c]);

        // R9: without a read the return path stays quiet.
        a_r9_quiet_without_read: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_rd[c] |=> (!bus_rvalid[c] && bus_rdata[c*DATA_W +: DATA_W] == '0));

        // R8: an acknowledge read during an active request returns ID 0.
        a_r8_ack_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd[c] && bus_addr[c*8 +: 8] == OFF_ACK && db_req[c])
            |=> bus_rdata[c*DATA_W +: DATA_W] == '0);

        // R7: a request needs a pending doorbell that is enabled.
        a_r7_req_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
            db_req[c] |-> |(cause_flat[c*N_BELL +: N_BELL] & mask_flat[c*N_BELL +: N_BELL]));

        // R5: without a cause write, pending bits are never lost.
        a_r5_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_wr[c] && bus_addr[c*8 +: 8] == OFF_CAUSE)
            |=> ((cause_flat[c*N_BELL +: N_BELL] & $past(cause_flat[c*N_BELL +: N_BELL]))
                 == $past(cause_flat[c*N_BELL +: N_BELL])));
    end

endmodule

bind db_doorbell_unit db_doorbell_unit_sva #(
    .N_CPU (N_CPU),
    .N_BELL(N_BELL),
    .DATA_W(DATA_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .db_req    (db_req),
    .cause_flat(cause_flat),
    .mask_flat (mask_flat)
);

// File: tb/db_doorbell_unit_test.sv
module db_doorbell_unit_test;

    localparam int N  = 4;
    localparam int NB = 8;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    b_wr = '0;
    logic [N-1:0]    b_rd = '0;
    logic [N*8-1:0]  b_addr = '0;
    logic [N*DW-1:0] b_wdata = '0;
    logic [N*DW-1:0] b_rdata;
    logic [N-1:0]    b_rvalid;
    logic [N-1:0]    db_req;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [NB-1:0] m_cause [N];
    logic [NB-1:0] m_mask  [N];
    logic          m_gate  [N];

    always #10 clk = ~clk;

    db_doorbell_unit #(.N_CPU(N), .N_BELL(NB), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .bus_rvalid(b_rvalid), .db_req(db_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_req(input int c);
        return m_gate[c] && |(m_cause[c] & m_mask[c]);
    endfunction

    // Expected read value of CPU c at offset a from the current model.
    function automatic logic [31:0] m_read(input int c, input logic [7:0] a);
        case (a)
            8'h88:   return {24'd0, m_cause[c]};
            8'h8C:   return {24'd0, m_mask[c]};
            8'h90:   return {31'd0, m_gate[c]};
            8'hC4:   return m_req(c) ? 32'd0 : 32'd1023;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h88:   return "R2";
            8'h8C:   return "R6";
            8'h90:   return "R10";
            8'hC4:   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic drv_wr(input int c, input logic [7:0] a, input logic [31:0] d);
        b_wr[c] = 1'b1;
        b_addr[c*8 +: 8] = a;
        b_wdata[c*DW +: DW] = d;
    endtask

    task automatic drv_rd(input int c, input logic [7:0] a);
        b_rd[c] = 1'b1;
        b_addr[c*8 +: 8] = a;
    endtask

    // One clock: update the model, advance, then compare requests and reads.
    task automatic step();
        logic [31:0]   exp_rd [N];
        logic [NB-1:0] sets   [N];
        logic          was_rd [N];
        for (int c = 0; c < N; c++) begin
            exp_rd[c] = m_read(c, b_addr[c*8 +: 8]);
            was_rd[c] = b_rd[c];
            sets[c]   = '0;
        end
        for (int s = 0; s < N; s++) begin
            if (b_wr[s] && b_addr[s*8 +: 8] == 8'h04 && b_wdata[s*DW +: 8] < 8'(NB)) begin
                for (int t = 0; t < N; t++) begin
                    if (b_wdata[s*DW + 8 + t]) sets[t][b_wdata[s*DW +: 3]] = 1'b1;
                end
            end
        end
        for (int c = 0; c < N; c++) begin
            if (b_wr[c] && b_addr[c*8 +: 8] == 8'h88) m_cause[c] = b_wdata[c*DW +: NB];
            if (b_wr[c] && b_addr[c*8 +: 8] == 8'h8C) m_mask[c]  = b_wdata[c*DW +: NB];
            if (b_wr[c] && b_addr[c*8 +: 8] == 8'h90) m_gate[c]  = b_wdata[c*DW];
            m_cause[c] = m_cause[c] | sets[c];
        end
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < N; c++) begin
            chk("R7", {31'd0, db_req[c]}, {31'd0, m_req(c)});
            chk("R9", {31'd0, b_rvalid[c]}, {31'd0, was_rd[c]});
            chk(was_rd[c] ? tag_of(b_addr[c*8 +: 8]) : "R9", b_rdata[c*DW +: DW],
                was_rd[c] ? exp_rd[c] : 32'd0);
        end
        b_wr = '0;
        b_rd = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < N; c++) begin
            m_cause[c] = '0; m_mask[c] = '0; m_gate[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports.
        chk("R1", {28'd0, db_req}, 32'd0);
        chk("R1", {28'd0, b_rvalid}, 32'd0);
        chk("R1", b_rdata[31:0], 32'd0);
        for (int c = 0; c < N; c++) drv_rd(c, 8'h88);
        step();
        for (int c = 0; c < N; c++) chk("R1", b_rdata[c*DW +: DW], 32'd0);

        // Enable every doorbell and gate on all CPUs.
        for (int c = 0; c < N; c++) drv_wr(c, 8'h8C, 32'hFFFF_FFFF);
        step();
        for (int c = 0; c < N; c++) drv_wr(c, 8'h90, 32'd1);
        step();

        // R2: broadcast doorbell 7 from CPU0.
        drv_wr(0, 8'h04, 32'h0000_0F07);
        step();
        chk("R2", {28'd0, db_req}, 32'hF);
        for (int c = 0; c < N; c++) drv_rd(c, 8'h88);
        step();
        for (int c = 0; c < N; c++) chk("R2", b_rdata[c*DW +: DW], 32'h80);

        // R5: writing 0 clears all pending doorbells.
        for (int c = 0; c < N; c++) drv_wr(c, 8'h88, 32'd0);
        step();
        chk("R5", {28'd0, db_req}, 32'h0);

        // R3: out-of-range number and empty map change nothing.
        drv_wr(2, 8'h04, 32'h0000_0F08);
        drv_wr(3, 8'h04, 32'h0000_0003);
        drv_wr(1, 8'h50, 32'hFFFF_FFFF);
        step();
        chk("R3", {28'd0, db_req}, 32'h0);
        for (int c = 0; c < N; c++) drv_rd(c, 8'h88);
        step();
        for (int c = 0; c < N; c++) chk("R3", b_rdata[c*DW +: DW], 32'h0);

        // R4 and R5: merged triggers plus a cause write on the target in one cycle.
        drv_wr(0, 8'h88, 32'h0000_0001);
        drv_wr(1, 8'h04, 32'h0000_0102);
        drv_wr(2, 8'h04, 32'h0000_0105);
        drv_wr(3, 8'h04, 32'h0000_0202);
        step();
        drv_rd(0, 8'h88);
        drv_rd(1, 8'h88);
        step();
        chk("R4", b_rdata[0 +: DW], 32'h25);
        chk("R4", b_rdata[DW +: DW], 32'h04);

        // R5: trigger wins over a clearing write for its bit.
        drv_wr(0, 8'h88, 32'h0);
        drv_wr(1, 8'h04, 32'h0000_0106);
        step();
        drv_rd(0, 8'h88);
        step();
        chk("R5", b_rdata[0 +: DW], 32'h40);

        // R8 and R10: gate off gives the spurious ID.
        drv_wr(0, 8'h90, 32'h0);
        step();
        drv_rd(0, 8'hC4);
        drv_rd(1, 8'hC4);
        step();
        chk("R8", b_rdata[0 +: DW], 32'd1023);
        chk("R8", b_rdata[DW +: DW], 32'd0);

        // Random mix of traffic on every port.
        for (int i = 0; i < 3000; i++) begin
            for (int c = 0; c < N; c++) begin
                int op;
                op = int'($urandom % 7);
                case (op)
                    1, 2: drv_wr(c, 8'h04, {20'd0, 4'($urandom), 8'($urandom % 10)});
                    3: drv_wr(c, 8'h88, ($urandom % 4 == 0) ? 32'd0 : $urandom);
                    4: drv_wr(c, 8'h8C, $urandom);
                    5: drv_wr(c, 8'h90, {31'd0, ($urandom % 4) != 0});
                    6: begin
                        logic [7:0] a;
                        case ($urandom % 6)
                            0: a = 8'h88;
                            1: a = 8'h8C;
                            2: a = 8'h90;
                            3: a = 8'hC4;
                            4: a = 8'h04;
                            default: a = 8'h20;
                        endcase
                        drv_rd(c, a);
                    end
                    default: ;
                endcase
            end
            step();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule